// File: doc/BRIEF.md
# Two-Reservoir Token Release Sequencer

This block controls token release for a pulse network fed from two reservoirs, blue and red. Software, or a neighbouring block, loads both reservoir counts with a start pulse. From then on every lever-hit pulse that arrives from the network asks the matching reservoir to release one token. If that reservoir still holds a token, the block answers with a one-cycle release pulse and decrements the count. If the reservoir is empty, nothing is released and a sticky starved flag records the miss.

A phase of the machine is one blue pass followed by a run of red trigger passes. The block tracks this with a mode bit: it goes to red on each red release and back to blue on each blue release. A phase index advances with every blue release. A done flag rises once a release or a load leaves both reservoirs empty.

For a network with n inputs and f duplicators, the usual load is n blue tokens and n*(1+f) red tokens. That covers up to f+1 red trigger passes per phase: one for each pending duplicate, plus one to confirm that none remain.

Top module: `marble_release_seq`

## Requirements
- R1: While rst_ni is low and after it rises, with no start seen yet, both counts read 0, both release pulses and both starved flags are 0, red_mode_o is 0 (blue) and phase_o and done_o are 0.
- R2: A start_i pulse loads blue_load_i and red_load_i into the counts, clears both starved flags, sets red_mode_o to 0 and phase_o to 0. Lever hits in the same cycle are ignored.
- R3: A blue_hit_i with a nonzero blue count makes blue_release_o high for exactly the one cycle after the sampling edge, and the blue count drops by one at that edge.
- R4: A red_hit_i with a nonzero red count, and no blue_hit_i in the same cycle, makes red_release_o high for exactly one cycle, and the red count drops by one.
- R5: A hit on an empty reservoir releases nothing and leaves its count at 0. It sets that reservoir's starved flag, which then stays 1 until the next start_i.
- R6: When blue_hit_i and red_hit_i are high in the same cycle, only the blue hit is serviced. The red count, red release and red starved flag are left unchanged.
- R7: red_mode_o becomes 1 on a red release and 0 on a blue release. It does not change on a starved hit.
- R8: phase_o increments by one on each blue release, modulo 2^PHASE_W.
- R9: done_o is updated only by a start or a release. It becomes 1 when both counts are 0 after that event and 0 otherwise.
- R10: blue_release_o and red_release_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load both reservoir counts |
| blue_load_i | input | CNT_W | Blue count to load |
| red_load_i | input | CNT_W | Red count to load |
| blue_hit_i | input | 1 | Blue lever hit pulse |
| red_hit_i | input | 1 | Red lever hit pulse |
| blue_release_o | output | 1 | One-cycle blue token release |
| red_release_o | output | 1 | One-cycle red token release |
| blue_left_o | output | CNT_W | Blue tokens remaining |
| red_left_o | output | CNT_W | Red tokens remaining |
| blue_starved_o | output | 1 | Sticky: blue hit while blue empty |
| red_starved_o | output | 1 | Sticky: red hit while red empty |
| red_mode_o | output | 1 | 1 = red part of phase, 0 = blue part |
| phase_o | output | PHASE_W | Blue releases since start |
| done_o | output | 1 | Both reservoirs emptied |

## Verification
A wrong count inside the block shows at blue_left_o or red_left_o on the very next cycle. It then shows again when a release pulse appears or fails to appear on a later hit. A wrong mode, phase or done register shows at its port one cycle after the hit that should have moved it. A stuck starved flag only shows when a start fails to clear it. Every check is therefore made at the first negative edge after the sampling edge, against a model that steps through sweeps of load values and hit orders.

// File: rtl/marble_seq_pkg.sv
package marble_seq_pkg;
  localparam int unsigned NUM_RES  = 2;
  localparam int unsigned RES_BLUE = 0;
  localparam int unsigned RES_RED  = 1;

  typedef enum logic {
    MODE_BLUE = 1'b0,
    MODE_RED  = 1'b1
  } mode_e;
endpackage

// File: rtl/token_pool.sv
module token_pool #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             take_i,
  output logic             fire_o,
  output logic             rel_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             starved_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rel_q, starved_q, empty;

  assign empty  = (cnt_q == '0);
  assign fire_o = take_i & ~empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rel_q     <= 1'b0;
      starved_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= load_val_i;
      rel_q     <= 1'b0;
      starved_q <= 1'b0;
    end else begin
      rel_q <= fire_o;
      if (fire_o) cnt_q <= cnt_q - 1'b1;
      if (take_i && empty) starved_q <= 1'b1;
    end
  end

  assign rel_o     = rel_q;
  assign cnt_o     = cnt_q;
  assign starved_o = starved_q;
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
  import marble_seq_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   blue_load_i,
  input  logic [CNT_W-1:0]   red_load_i,
  input  logic               blue_fire_i,
  input  logic               red_fire_i,
  input  logic [CNT_W-1:0]   blue_cnt_i,
  input  logic [CNT_W-1:0]   red_cnt_i,
  output logic               red_mode_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               done_o
);
  mode_e              mode_q;
  logic [PHASE_W-1:0] phase_q;
  logic               done_q;
  logic [CNT_W-1:0]   blue_after, red_after;

  // counts as they stand after this edge
  assign blue_after = blue_cnt_i - CNT_W'(blue_fire_i);
  assign red_after  = red_cnt_i  - CNT_W'(red_fire_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_BLUE;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else if (load_i) begin
      mode_q  <= MODE_BLUE;
      phase_q <= '0;
      done_q  <= (blue_load_i == '0) && (red_load_i == '0);
    end else if (blue_fire_i || red_fire_i) begin
      mode_q <= blue_fire_i ? MODE_BLUE : MODE_RED;
      if (blue_fire_i) phase_q <= phase_q + 1'b1;
      done_q <= (blue_after == '0) && (red_after == '0);
    end
  end

  assign red_mode_o = (mode_q == MODE_RED);
  assign phase_o    = phase_q;
  assign done_o     = done_q;
endmodule

// File: rtl/marble_release_seq.sv
module marble_release_seq
  import marble_seq_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   blue_load_i,
  input  logic [CNT_W-1:0]   red_load_i,
  input  logic               blue_hit_i,
  input  logic               red_hit_i,
  output logic               blue_release_o,
  output logic               red_release_o,
  output logic [CNT_W-1:0]   blue_left_o,
  output logic [CNT_W-1:0]   red_left_o,
  output logic               blue_starved_o,
  output logic               red_starved_o,
  output logic               red_mode_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               done_o
);
  logic [NUM_RES-1:0]            take, fire, rel, starved;
  logic [NUM_RES-1:0][CNT_W-1:0] load_val, cnt;

  // start wins over hits; blue wins over red
  assign take[RES_BLUE] = blue_hit_i & ~start_i;
  assign take[RES_RED]  = red_hit_i & ~blue_hit_i & ~start_i;

  assign load_val[RES_BLUE] = blue_load_i;
  assign load_val[RES_RED]  = red_load_i;

  for (genvar g = 0; g < NUM_RES; g++) begin : g_pool
    token_pool #(.CNT_W(CNT_W)) u_pool (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (start_i),
      .load_val_i (load_val[g]),
      .take_i     (take[g]),
      .fire_o     (fire[g]),
      .rel_o      (rel[g]),
      .cnt_o      (cnt[g]),
      .starved_o  (starved[g])
    );
  end

  phase_tracker #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .blue_load_i (blue_load_i),
    .red_load_i  (red_load_i),
    .blue_fire_i (fire[RES_BLUE]),
    .red_fire_i  (fire[RES_RED]),
    .blue_cnt_i  (cnt[RES_BLUE]),
    .red_cnt_i   (cnt[RES_RED]),
    .red_mode_o  (red_mode_o),
    .phase_o     (phase_o),
    .done_o      (done_o)
  );

  assign blue_release_o = rel[RES_BLUE];
  assign red_release_o  = rel[RES_RED];
  assign blue_left_o    = cnt[RES_BLUE];
  assign red_left_o     = cnt[RES_RED];
  assign blue_starved_o = starved[RES_BLUE];
  assign red_starved_o  = starved[RES_RED];
endmodule

// File: rtl/marble_release_seq_chk.sv
module marble_release_seq_chk #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PHASE_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               blue_hit_i,
  input logic               red_hit_i,
  input logic               blue_release_o,
  input logic               red_release_o,
  input logic [CNT_W-1:0]   blue_left_o,
  input logic [CNT_W-1:0]   red_left_o,
  input logic               blue_starved_o,
  input logic               red_starved_o,
  input logic               red_mode_o,
  input logic [PHASE_W-1:0] phase_o,
  input logic               done_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  p_excl_rel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(blue_release_o && red_release_o));

  p_blue_rel_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    blue_release_o |-> $past(blue_hit_i) && !$past(start_i));

  p_blue_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    blue_release_o |-> blue_left_o == $past(blue_left_o) - 1'b1);

  p_red_rel_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    red_release_o |-> $past(red_hit_i) && !$past(blue_hit_i) && !$past(start_i));

  p_blue_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    ($past(blue_starved_o) && !$past(start_i)) |-> blue_starved_o);

  p_red_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    ($past(red_starved_o) && !$past(start_i)) |-> red_starved_o);

  p_mode_red_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_release_o |-> red_mode_o);

  p_mode_blue_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blue_release_o |-> !red_mode_o);

  p_done_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (blue_left_o == '0) && (red_left_o == '0));
endmodule

bind marble_release_seq marble_release_seq_chk #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .blue_hit_i     (blue_hit_i),
  .red_hit_i      (red_hit_i),
  .blue_release_o (blue_release_o),
  .red_release_o  (red_release_o),
  .blue_left_o    (blue_left_o),
  .red_left_o     (red_left_o),
  .blue_starved_o (blue_starved_o),
  .red_starved_o  (red_starved_o),
  .red_mode_o     (red_mode_o),
  .phase_o        (phase_o),
  .done_o         (done_o)
);

// File: tb/marble_release_seq_test.sv
module marble_release_seq_test;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned PHASE_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, blue_hit_i = 1'b0, red_hit_i = 1'b0;
  logic [CNT_W-1:0] blue_load_i = '0, red_load_i = '0;
  logic blue_release_o, red_release_o, blue_starved_o, red_starved_o, red_mode_o, done_o;
  logic [CNT_W-1:0] blue_left_o, red_left_o;
  logic [PHASE_W-1:0] phase_o;

  int errors = 0, checks = 0;
  // model
  int mb, mr, mphase, mbrel, mrrel;
  bit msb, msr, mmode, mdone;

  always #4 clk_i = ~clk_i;  // 125 MHz

  marble_release_seq #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "blue_release", int'(blue_release_o), mbrel);
    chk(req, "red_release",  int'(red_release_o),  mrrel);
    chk(req, "blue_left",    int'(blue_left_o),    mb);
    chk(req, "red_left",     int'(red_left_o),     mr);
    chk(req, "blue_starved", int'(blue_starved_o), int'(msb));
    chk(req, "red_starved",  int'(red_starved_o),  int'(msr));
    chk(req, "red_mode",     int'(red_mode_o),     int'(mmode));
    chk(req, "phase",        int'(phase_o),        mphase);
    chk(req, "done",         int'(done_o),         int'(mdone));
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step(bit b, bit r, string req);
    blue_hit_i = b; red_hit_i = r;
    @(posedge clk_i);
    mbrel = 0; mrrel = 0;
    if (b) begin
      if (mb > 0) begin
        mb--; mbrel = 1; mmode = 0; mphase = (mphase + 1) % (1 << PHASE_W);
        mdone = (mb == 0) && (mr == 0);
      end else msb = 1;  // R6: red ignored when blue present
    end else if (r) begin
      if (mr > 0) begin
        mr--; mrrel = 1; mmode = 1;
        mdone = (mb == 0) && (mr == 0);
      end else msr = 1;
    end
    @(negedge clk_i);
    blue_hit_i = 1'b0; red_hit_i = 1'b0;
    check_all(req);
  endtask

  task automatic load(int b, int r);
    start_i = 1'b1; blue_load_i = CNT_W'(b); red_load_i = CNT_W'(r);
    blue_hit_i = 1'b1; red_hit_i = 1'b1;  // R2: hits ignored during start
    @(posedge clk_i);
    mb = b; mr = r; msb = 0; msr = 0; mmode = 0; mphase = 0; mbrel = 0; mrrel = 0;
    mdone = (b == 0) && (r == 0);
    @(negedge clk_i);
    start_i = 1'b0; blue_hit_i = 1'b0; red_hit_i = 1'b0;
    check_all("R2");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mb = 0; mr = 0; mphase = 0; mbrel = 0; mrrel = 0;
    msb = 0; msr = 0; mmode = 0; mdone = 0;
    repeat (3) @(negedge clk_i);
    check_all("R1");  // in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");
    // starved hit before any start: R5, R9 done unchanged
    step(1, 0, "R5");
    step(0, 1, "R5");
    for (int b = 0; b < 8; b++) begin
      for (int r = 0; r < 8; r++) begin
        load(b, r);
        // phases: one blue pass, then a run of red trigger passes
        for (int p = 0; p < 6; p++) begin
          step(1, 0, "R3 R8");
          step(0, 0, "R3 pulse one cycle");
          for (int k = 0; k <= (p + b) % 3; k++) step(0, 1, "R4 R7");
          step(1, 1, "R6 R10");
          step(0, 1, "R7 R9");
          step(0, 0, "R4 pulse one cycle");
        end
        step(0, 1, "R5 red empty");
        step(1, 0, "R5 blue empty");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule